// File: doc/BRIEF.md
# Management-Memory Access Gate

This block sits between the processor's memory request path and the DRAM side. It inspects each request and decides whether the request may touch one of three protected management-memory windows. Two windows have fixed addresses: a legacy window low in memory and a window just below the 4 GiB line. The third window has a base and byte count that firmware programs. When the processor is not running in its management mode, a protected window looks like an absent device. Reads from it return all-ones bytes and writes to it never reach memory.

Firmware uses a small register port to program the third window. The same port holds two control bits. An open bit lets normal-mode code reach the protected windows so that the handlers can be loaded. A lock bit can only be set, and only reset clears it. Once it is set, the open bit and the window setup can no longer change. Every request completes in the cycle it is presented. A registered response follows one cycle later and reports the read data, which window was hit and whether the access was refused.

Top module: `smram_gate`

## Requirements
- R1: An access that touches any byte of 0x000A0000..0x000BFFFF reports region code 1 on `rsp_region`.
- R2: An access that touches any byte of 0xFEDA0000..0xFEDBFFFF reports region code 2 on `rsp_region`.
- R3: The programmable window covers addresses base through base+size-1. It reports region code 3, and a size of zero disables it. An access that hits no window reports code 0.
- R4: An access covers req_addr through req_addr+req_len. It counts as a hit as soon as any one of its bytes lies in a window. When several windows are touched, code 1 wins over code 2 and code 2 wins over code 3.
- R5: Take a hit with `cpu_smm` low and the open bit clear. It is refused: `mem_valid` stays low, `rsp_blocked` is 1, and a read returns all ones on `rsp_rdata`.
- R6: While the open bit is set, normal-mode hits are forwarded to memory and return memory data.
- R7: A request with `cpu_smm` high is always forwarded, whatever the open bit holds.
- R8: Config register 0 holds the open bit in bit 0 and the lock bit in bit 1. Once the lock bit is 1, it stays 1 until reset. No later write can change the open bit or clear the lock bit.
- R9: While locked, writes to register 1 (window base) and register 2 (window size) have no effect. Register 3 always reads zero.
- R10: `req_ready` is always high. A request produces `rsp_valid` exactly one cycle later. A request that hits no window is always forwarded. A forwarded read returns the memory data, and a write returns zero data.
- R11: After reset, every config register reads zero and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always accepting |
| req_addr | input | AW | First byte address |
| req_len | input | LEN_W | Bytes in access minus one |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| cpu_smm | input | 1 | Processor is in management mode |
| cfg_we | input | 1 | Config register write strobe |
| cfg_sel | input | 2 | Config register select (0 ctrl, 1 base, 2 size) |
| cfg_wdata | input | AW | Config write data |
| cfg_rdata | output | AW | Config read data for `cfg_sel` |
| mem_valid | output | 1 | Forwarded request to memory |
| mem_addr | output | AW | Forwarded address |
| mem_len | output | LEN_W | Forwarded length |
| mem_write | output | 1 | Forwarded direction |
| mem_wdata | output | DW | Forwarded write data |
| mem_rdata | input | DW | Memory read data, same cycle |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DW | Read data, all ones when refused, zero for writes |
| rsp_region | output | 2 | 0 none, 1 low, 2 high, 3 programmable |
| rsp_blocked | output | 1 | Request was refused |

## Verification
The checker watches several properties on every cycle. A management-mode request always reaches memory, and memory is never driven without a request. A refused response always names a region and traces back to a normal-mode, closed-gate request. A refused read always carries all ones. The lock bit is sticky, and once locked the open bit, base and size stay frozen. Other behaviours can only be shown by the bench's scenarios against its own model: the exact window edges, the partial-overlap and priority cases, the zero-size disable, and the data returned for forwarded reads.

// File: rtl/smram_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the management-memory access gate.
// Assumes byte addressing; fixed windows are given as 64-bit constants
// and narrowed by each user to its own address width.
package smram_pkg;

    localparam int NUM_REGIONS = 3;

    typedef enum logic [1:0] {
        REGION_NONE = 2'd0,
        REGION_LOW  = 2'd1,
        REGION_HIGH = 2'd2,
        REGION_TOP  = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        CFG_CTRL  = 2'd0,
        CFG_BASE  = 2'd1,
        CFG_SIZE  = 2'd2,
        CFG_SPARE = 2'd3
    } cfg_sel_e;

    localparam int CTRL_OPEN_BIT = 0;
    localparam int CTRL_LOCK_BIT = 1;

    localparam logic [63:0] LOW_FIRST  = 64'h0000_0000_000A_0000;
    localparam logic [63:0] LOW_LAST   = 64'h0000_0000_000B_FFFF;
    localparam logic [63:0] HIGH_FIRST = 64'h0000_0000_FEDA_0000;
    localparam logic [63:0] HIGH_LAST  = 64'h0000_0000_FEDB_FFFF;

endpackage

// File: rtl/smram_cfg_regs.sv
`timescale 1ns/1ps
// Control and window registers. Holds the open bit, the sticky lock bit and
// the programmable window base and size. Assumes one write per cycle; once
// the lock bit is 1, every write is dropped until reset.
module smram_cfg_regs
    import smram_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [AW-1:0] wdata,
    output logic          open_q,
    output logic          lock_q,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] size_q,
    output logic [AW-1:0] rdata
);

    // Register update: writes accepted only while the lock bit is clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            lock_q <= 1'b0;
            base_q <= '0;
            size_q <= '0;
        end else if (we && !lock_q) begin
            case (cfg_sel_e'(sel))
                CFG_CTRL: begin
                    open_q <= wdata[CTRL_OPEN_BIT];
                    lock_q <= wdata[CTRL_LOCK_BIT];
                end
                CFG_BASE: base_q <= wdata;
                CFG_SIZE: size_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Read mux for the selected register.
    always_comb begin
        rdata = '0;
        case (cfg_sel_e'(sel))
            CFG_CTRL: begin
                rdata[CTRL_OPEN_BIT] = open_q;
                rdata[CTRL_LOCK_BIT] = lock_q;
            end
            CFG_BASE: rdata = base_q;
            CFG_SIZE: rdata = size_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/smram_range_match.sv
`timescale 1ns/1ps
// Overlap test between one access and one inclusive address window.
// Bounds carry one extra bit so that neither the access end nor the window
// end can wrap past the top of the address space.
module smram_range_match #(
    parameter int AW    = 32,
    parameter int LEN_W = 3
) (
    input  logic             en,
    input  logic [AW:0]      first,
    input  logic [AW:0]      last,
    input  logic [AW-1:0]    addr,
    input  logic [LEN_W-1:0] len,
    output logic             hit
);

    logic [AW:0] acc_first;
    logic [AW:0] acc_last;

    // Span of the access in widened arithmetic.
    always_comb begin
        acc_first = {1'b0, addr};
        acc_last  = acc_first + (AW+1)'(len);
    end

    // Any shared byte counts as a hit.
    assign hit = en && (acc_last >= first) && (acc_first <= last);

endmodule

// File: rtl/smram_rsp_stage.sv
`timescale 1ns/1ps
// Response register. Captures the verdict of the current request and the
// memory read data, and presents them one cycle later. Refused reads are
// replaced by all ones; writes answer with zero data.
module smram_rsp_stage #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic          acc_blocked,
    input  logic [1:0]    acc_region,
    input  logic [DW-1:0] mem_rdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [1:0]    rsp_region,
    output logic          rsp_blocked
);

    // Register the response for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            rsp_region  <= '0;
            rsp_blocked <= 1'b0;
        end else begin
            rsp_valid <= acc_valid;
            if (acc_valid) begin
                rsp_region  <= acc_region;
                rsp_blocked <= acc_blocked;
                if (acc_write)
                    rsp_rdata <= '0;
                else if (acc_blocked)
                    rsp_rdata <= '1;
                else
                    rsp_rdata <= mem_rdata;
            end
        end
    end

endmodule

// File: rtl/smram_gate.sv
`timescale 1ns/1ps
// Management-memory access gate (top). Decodes each request against the low,
// high and programmable windows, picks the region by fixed priority, and
// forwards the request to memory unless it hits a window from normal mode
// with the gate closed. Assumes memory returns read data in the same cycle.
module smram_gate
    import smram_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 64,
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_write,
    input  logic [DW-1:0]    req_wdata,
    input  logic             cpu_smm,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    output logic [AW-1:0]    cfg_rdata,
    output logic             mem_valid,
    output logic [AW-1:0]    mem_addr,
    output logic [LEN_W-1:0] mem_len,
    output logic             mem_write,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic [1:0]       rsp_region,
    output logic             rsp_blocked
);

    logic                   ctrl_open;
    logic                   ctrl_lock;
    logic [AW-1:0]          top_base;
    logic [AW-1:0]          top_size;
    logic [AW:0]            win_first [NUM_REGIONS];
    logic [AW:0]            win_last  [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] win_en;
    logic [NUM_REGIONS-1:0] win_hit;
    region_e                region;
    logic                   allowed;

    smram_cfg_regs #(.AW(AW)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .open_q (ctrl_open),
        .lock_q (ctrl_lock),
        .base_q (top_base),
        .size_q (top_size),
        .rdata  (cfg_rdata)
    );

    // Window bounds: two fixed, one from the config registers.
    always_comb begin
        win_first[0] = (AW+1)'(LOW_FIRST);
        win_last[0]  = (AW+1)'(LOW_LAST);
        win_en[0]    = 1'b1;
        win_first[1] = (AW+1)'(HIGH_FIRST);
        win_last[1]  = (AW+1)'(HIGH_LAST);
        win_en[1]    = 1'b1;
        win_first[2] = {1'b0, top_base};
        win_last[2]  = {1'b0, top_base} + {1'b0, top_size} - (AW+1)'(1);
        win_en[2]    = |top_size;
    end

    // One overlap comparator per window.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        smram_range_match #(.AW(AW), .LEN_W(LEN_W)) u_match (
            .en    (win_en[g]),
            .first (win_first[g]),
            .last  (win_last[g]),
            .addr  (req_addr),
            .len   (req_len),
            .hit   (win_hit[g])
        );
    end

    // Priority pick: lowest index wins.
    always_comb begin
        region = REGION_NONE;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (win_hit[i])
                region = region_e'(2'(i + 1));
        end
    end

    // Access verdict: protected hits pass only in management mode or when open.
    assign allowed = (region == REGION_NONE) || cpu_smm || ctrl_open;

    // Forwarding to memory.
    assign req_ready = 1'b1;
    assign mem_valid = req_valid && allowed;
    assign mem_addr  = req_addr;
    assign mem_len   = req_len;
    assign mem_write = req_write;
    assign mem_wdata = req_wdata;

    smram_rsp_stage #(.DW(DW)) u_rsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (req_valid),
        .acc_write   (req_write),
        .acc_blocked (!allowed),
        .acc_region  (region),
        .mem_rdata   (mem_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .rsp_region  (rsp_region),
        .rsp_blocked (rsp_blocked)
    );

endmodule

// File: rtl/smram_gate_chk.sv
`timescale 1ns/1ps
// Property checker for the access gate, attached by bind. Observes ports and
// the config register state; drives nothing.
module smram_gate_chk #(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic          cpu_smm,
    input logic          mem_valid,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_rdata,
    input logic [1:0]    rsp_region,
    input logic          rsp_blocked,
    input logic          ctrl_open,
    input logic          ctrl_lock,
    input logic [AW-1:0] top_base,
    input logic [AW-1:0] top_size
);

    assert_smm_forwards_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cpu_smm |-> mem_valid);

    assert_no_phantom_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> req_valid);

    assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_block_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_blocked == ($past(!cpu_smm && !ctrl_open) && rsp_blocked)));

    assert_block_has_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_blocked |-> rsp_region != 2'd0);

    assert_block_all_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> (!rsp_blocked || (&rsp_rdata)));

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_lock |=> ctrl_lock);

    assert_open_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_lock |=> $stable(ctrl_open));

    assert_window_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_lock |=> $stable(top_base) && $stable(top_size));

endmodule

bind smram_gate smram_gate_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .cpu_smm     (cpu_smm),
    .mem_valid   (mem_valid),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_region  (rsp_region),
    .rsp_blocked (rsp_blocked),
    .ctrl_open   (ctrl_open),
    .ctrl_lock   (ctrl_lock),
    .top_base    (top_base),
    .top_size    (top_size)
);

// File: tb/tb_smram_gate.sv
`timescale 1ns/1ps
module tb_smram_gate;

    localparam int AW = 32;
    localparam int DW = 64;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          cpu_smm = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic          mem_valid;
    logic [AW-1:0] mem_addr;
    logic [LW-1:0] mem_len;
    logic          mem_write;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [1:0]    rsp_region;
    logic          rsp_blocked;

    int errors = 0;
    int checks = 0;

    // Bench model of the config state.
    logic          m_open = 1'b0;
    logic          m_lock = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [AW-1:0] m_size = '0;

    always #4 clk = ~clk;

    // Memory model: data is a function of the address.
    assign mem_rdata = {~mem_addr, mem_addr};

    smram_gate #(.AW(AW), .DW(DW), .LEN_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
        .req_wdata(req_wdata), .cpu_smm(cpu_smm), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_write(mem_write), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_region(rsp_region),
        .rsp_blocked(rsp_blocked)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] got,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic overlaps(input logic [32:0] a0, input logic [32:0] a1,
                                      input logic [32:0] w0, input logic [32:0] w1);
        return (a1 >= w0) && (a0 <= w1);
    endfunction

    // Expected region code from the requirements (R1..R4).
    function automatic int exp_region(input logic [AW-1:0] a, input logic [LW-1:0] l);
        logic [32:0] a0, a1;
        a0 = {1'b0, a};
        a1 = a0 + 33'(l);
        if (overlaps(a0, a1, 33'h000A0000, 33'h000BFFFF)) return 1;
        if (overlaps(a0, a1, 33'hFEDA0000, 33'hFEDBFFFF)) return 2;
        if (m_size != 0 &&
            overlaps(a0, a1, {1'b0, m_base}, {1'b0, m_base} + {1'b0, m_size} - 33'd1))
            return 3;
        return 0;
    endfunction

    task automatic cfg_write(input logic [1:0] s, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!m_lock) begin
            case (s)
                2'd0: begin m_open = d[0]; m_lock = d[1]; end
                2'd1: m_base = d;
                2'd2: m_size = d;
                default: ;
            endcase
        end
    endtask

    task automatic cfg_read(input logic [1:0] s, input logic [AW-1:0] exp, input string req);
        @(negedge clk);
        cfg_sel = s;
        #1;
        check(cfg_rdata == exp, req, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic do_req(input logic [AW-1:0] a, input logic [LW-1:0] l, input logic w,
                          input logic s, input string note);
        int er;
        logic allow;
        logic [DW-1:0] ed;
        string mt, rt;
        er = exp_region(a, l);
        allow = (er == 0) || s || m_open;
        mt = (er == 0) ? "R10" : s ? "R7" : m_open ? "R6" : "R5";
        rt = (note != "") ? note : (er == 1) ? "R1" : (er == 2) ? "R2" :
             (er == 3) ? "R3" : "R3-none";
        ed = w ? '0 : (allow ? {~a, a} : '1);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = l; req_write = w;
        cpu_smm = s; req_wdata = {a, ~a};
        #1;
        check(mem_valid == allow, mt, 64'(mem_valid), 64'(allow));
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, "R10", 64'(rsp_valid), 64'd1);
        check(rsp_region == 2'(er), rt, 64'(rsp_region), 64'(er));
        check(rsp_blocked == !allow, mt, 64'(rsp_blocked), 64'(!allow));
        check(rsp_rdata == ed, mt, rsp_rdata, ed);
    endtask

    function automatic logic [AW-1:0] pick_addr();
        case ($urandom % 5)
            0: return 32'h0009FFF0 + ($urandom % 32'h20020);
            1: return 32'hFED9FFF0 + ($urandom % 32'h20020);
            2: return m_base - 32'd16 + ($urandom % 32'h40);
            3: return m_base + m_size - 32'd16 + ($urandom % 32'h40);
            default: return $urandom;
        endcase
    endfunction

    task automatic random_burst(input int n);
        for (int i = 0; i < n; i++) begin
            do_req(pick_addr(), LW'($urandom), 1'($urandom), ($urandom % 3) == 0, "");
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        check(rsp_valid == 1'b0, "R11", 64'(rsp_valid), 64'd0);
        cfg_read(2'd0, '0, "R11");
        cfg_read(2'd1, '0, "R11");
        cfg_read(2'd2, '0, "R11");
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10", 64'(rsp_valid), 64'd0);

        // R1 edges of the low window, R4 partial overlap
        do_req(32'h0009FFFF, 3'd0, 1'b0, 1'b0, "R1");
        do_req(32'h000A0000, 3'd0, 1'b0, 1'b0, "R1");
        do_req(32'h000BFFFF, 3'd0, 1'b0, 1'b0, "R1");
        do_req(32'h000C0000, 3'd7, 1'b0, 1'b0, "R1");
        do_req(32'h0009FFFC, 3'd3, 1'b0, 1'b0, "R4");
        do_req(32'h000BFFFC, 3'd7, 1'b1, 1'b0, "R4");
        // R2 edges of the high window
        do_req(32'hFED9FFFF, 3'd0, 1'b0, 1'b0, "R2");
        do_req(32'hFEDA0000, 3'd0, 1'b0, 1'b0, "R2");
        do_req(32'hFEDBFFFF, 3'd0, 1'b0, 1'b0, "R2");
        do_req(32'hFEDC0000, 3'd0, 1'b0, 1'b0, "R2");
        do_req(32'hFED9FFF9, 3'd7, 1'b0, 1'b0, "R4");
        // R3 disabled window with size zero
        cfg_write(2'd1, 32'h7F00_0000);
        do_req(32'h7F00_0000, 3'd0, 1'b0, 1'b0, "R3");
        // R3 programmable window edges
        cfg_write(2'd2, 32'h0010_0000);
        cfg_read(2'd1, 32'h7F00_0000, "R3");
        cfg_read(2'd2, 32'h0010_0000, "R3");
        do_req(32'h7EFF_FFFF, 3'd0, 1'b0, 1'b0, "R3");
        do_req(32'h7EFF_FFFF, 3'd1, 1'b0, 1'b0, "R4");
        do_req(32'h7F0F_FFFF, 3'd0, 1'b0, 1'b0, "R3");
        do_req(32'h7F10_0000, 3'd0, 1'b0, 1'b0, "R3");
        // R7 management-mode access reaches memory
        do_req(32'h7F00_0040, 3'd7, 1'b0, 1'b1, "R3");
        do_req(32'h000A1000, 3'd7, 1'b1, 1'b1, "R1");
        // R4 priority when the programmable window overlaps the low one
        cfg_write(2'd1, 32'h000B_0000);
        cfg_write(2'd2, 32'h0002_0000);
        do_req(32'h000B_8000, 3'd0, 1'b0, 1'b0, "R4");
        do_req(32'h000B_FFFC, 3'd7, 1'b0, 1'b0, "R4");
        do_req(32'h000C_8000, 3'd0, 1'b0, 1'b0, "R3");
        // Window at the very top of the address space
        cfg_write(2'd1, 32'hFFFF_F000);
        cfg_write(2'd2, 32'h0000_1000);
        do_req(32'hFFFF_FFFF, 3'd7, 1'b0, 1'b0, "R3");
        do_req(32'hFFFF_EFF9, 3'd7, 1'b0, 1'b0, "R4");
        // R6 open gate
        cfg_write(2'd0, 32'h1);
        cfg_read(2'd0, 32'h1, "R6");
        do_req(32'h000A_0000, 3'd0, 1'b0, 1'b0, "R1");
        do_req(32'hFEDA_0100, 3'd3, 1'b1, 1'b0, "R2");
        cfg_write(2'd0, 32'h0);
        do_req(32'h000A_0000, 3'd0, 1'b0, 1'b0, "R1");
        // R9 spare register always zero
        cfg_write(2'd3, 32'hFFFF_FFFF);
        cfg_read(2'd3, '0, "R9");

        // Random phase before locking
        for (int p = 0; p < 6; p++) begin
            cfg_write(2'd1, $urandom);
            cfg_write(2'd2, $urandom % 32'h0004_0000);
            cfg_write(2'd0, 32'($urandom % 2));
            random_burst(120);
        end

        // R8 lock with gate open, then try to change everything
        cfg_write(2'd1, 32'h4000_0000);
        cfg_write(2'd2, 32'h0000_8000);
        cfg_write(2'd0, 32'h3);
        cfg_read(2'd0, 32'h3, "R8");
        cfg_write(2'd0, 32'h0);
        cfg_read(2'd0, 32'h3, "R8");
        cfg_write(2'd1, 32'h1234_5678);
        cfg_write(2'd2, 32'h0);
        cfg_read(2'd1, 32'h4000_0000, "R9");
        cfg_read(2'd2, 32'h0000_8000, "R9");
        do_req(32'h4000_7FFF, 3'd0, 1'b0, 1'b0, "R9");
        random_burst(200);

        // R8 reset clears lock; closed gate and lock again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_open = 1'b0; m_lock = 1'b0; m_base = '0; m_size = '0;
        cfg_read(2'd0, '0, "R8");
        cfg_write(2'd1, 32'h2000_0000);
        cfg_write(2'd2, 32'h0001_0000);
        cfg_write(2'd0, 32'h2);
        cfg_write(2'd0, 32'h1);
        cfg_read(2'd0, 32'h2, "R8");
        do_req(32'h2000_0000, 3'd0, 1'b0, 1'b0, "R8");
        do_req(32'h2000_0000, 3'd0, 1'b1, 1'b0, "R5");
        do_req(32'h2000_0000, 3'd0, 1'b0, 1'b1, "R7");
        random_burst(300);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule